// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address. It walks a two-level page table held in memory. A root register gives the 4 KB-aligned base of the first-level table. Each level holds 1024 entries of 32 bits. A first-level entry either maps a 4 MB page directly (when large pages are enabled and its size flag is set) or points to a second-level table. A second-level entry maps a 4 KB page. When paging is disabled, the linear address is returned unchanged and no table is read.

Requests are accepted one at a time. Each request carries the linear address, a write flag and a user flag. Table entries are fetched over a simple read port. The port sends an address with a valid/ready handshake, and the data returns on a later cycle with a valid strobe. Only one read is outstanding at a time.

The walker ends every walk with a one-cycle response. That response holds either a physical address or a page fault with a 3-bit error code. The walker then returns to idle.

Top module: `ptw_top`

## Requirements
- R1: With `cfg_pg_en` low at acceptance, the response follows one cycle after the accepting edge. It carries `rsp_paddr` equal to the linear address and no fault, and no memory read is issued.
- R2: The first read address is root[31:12] followed by linear[31:22] followed by two zero bits.
- R3: For a table walk, the second read address is first-level entry[31:12] followed by linear[21:12] followed by two zero bits.
- R4: A successful 4 KB translation returns second-level entry[31:12] followed by linear[11:0].
- R5: If `cfg_lp_en` is high and first-level entry bit 7 is 1, exactly one read is made. A successful result is entry[31:22] followed by linear[21:0].
- R6: If `cfg_lp_en` is low or entry bit 7 is 0, the first-level entry is treated as a table pointer and a second read is made.
- R7: Entry bit 0 is the present flag. If it is 0 at either level, the walk ends with a fault and error code bit 0 set to 0.
- R8: Entry bit 1 grants write and bit 2 grants user access. A write faults if any visited entry has bit 1 clear. A user access faults if any visited entry has bit 2 clear. Such a fault has error code bit 0 set to 1.
- R9: On a fault, error code bit 1 equals the write flag and bit 2 equals the user flag, and `rsp_paddr` is 0. On success the error code is 0.
- R10: `req_ready` is high only when idle. `rsp_valid` is a one-cycle pulse, and the walker is idle in the cycle after it.
- R11: A read request holds its address stable until `mem_req_ready` is seen. Addresses are 4-byte aligned. A new read is issued only after the previous data has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request accepted |
| req_lin | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| cfg_root | input | 32 | Root table base (bits 31:12 used) |
| cfg_pg_en | input | 1 | Paging enable |
| cfg_lp_en | input | 1 | Large-page enable |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Read request taken |
| mem_req_addr | output | 32 | Entry address |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | 32 | Entry value |
| rsp_valid | output | 1 | Result strobe |
| rsp_fault | output | 1 | Page fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_ecode | output | 3 | Fault error code |

## Verification
The assertions check several properties on every cycle:
- the pass-through timing and value when paging is off, with no reads issued;
- that read requests are aligned and held until taken;
- that the ready, read-request and response strobes never overlap;
- that a successful result carries a zero error code;
- that idle always follows a response.

Other behaviours show only in the bench's scenarios against its reference model. These include the exact entry addresses, the 4 KB and 4 MB address assembly, and the choice between early termination and a second-level read. They also include whether a present or a rights violation occurs, and the write and user bits reported in the error code.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_DONE
    } walk_state_e;

    localparam int FLAG_PRESENT = 0;
    localparam int FLAG_WRITE   = 1;
    localparam int FLAG_USER    = 2;
    localparam int FLAG_LARGE   = 7;

    localparam int ECODE_W = 3;

endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic [ADDR_W-1:0] root,
    input  logic [ADDR_W-1:0] lin,
    input  logic [ADDR_W-1:0] tbl_entry,
    input  logic [ADDR_W-1:0] leaf_entry,
    output logic [ADDR_W-1:0] l1_addr,
    output logic [ADDR_W-1:0] l2_addr,
    output logic [ADDR_W-1:0] small_pa,
    output logic [ADDR_W-1:0] large_pa
);
    // log2 of entry size in bytes
    localparam int ENT_B   = OFF_W - IDX_W;
    localparam int LARGE_W = OFF_W + IDX_W;

    always_comb begin
        l1_addr  = {root[ADDR_W-1:OFF_W], lin[ADDR_W-1:LARGE_W], {ENT_B{1'b0}}};
        l2_addr  = {tbl_entry[ADDR_W-1:OFF_W], lin[LARGE_W-1:OFF_W], {ENT_B{1'b0}}};
        small_pa = {leaf_entry[ADDR_W-1:OFF_W], lin[OFF_W-1:0]};
        large_pa = {leaf_entry[ADDR_W-1:LARGE_W], lin[LARGE_W-1:0]};
    end

endmodule

// File: rtl/ptw_perm.sv
module ptw_perm
    import ptw_pkg::*;
(
    input  logic               present,
    input  logic               up_w,
    input  logic               up_u,
    input  logic               lo_w,
    input  logic               lo_u,
    input  logic               acc_w,
    input  logic               acc_u,
    output logic               fault,
    output logic [ECODE_W-1:0] ecode
);
    logic deny;

    always_comb begin
        deny  = (acc_w & ~(up_w & lo_w)) | (acc_u & ~(up_u & lo_u));
        fault = ~present | deny;
        ecode = fault ? {acc_u, acc_w, present} : '0;
    end

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 12,
    parameter int IDX_W  = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_lin,
    input  logic               req_write,
    input  logic               req_user,
    input  logic [ADDR_W-1:0]  cfg_root,
    input  logic               cfg_pg_en,
    input  logic               cfg_lp_en,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [ADDR_W-1:0]  mem_rsp_data,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [ADDR_W-1:0]  rsp_paddr,
    output logic [ECODE_W-1:0] rsp_ecode
);

    typedef struct packed {
        walk_state_e        state;
        logic [ADDR_W-1:0]  lin;
        logic               wr;
        logic               usr;
        logic [ADDR_W-1:0]  root;
        logic               lp;
        logic [ADDR_W-1:0]  e1;
        logic [ADDR_W-1:0]  paddr;
        logic               fault;
        logic [ECODE_W-1:0] ecode;
    } walk_s;

    walk_s q, d;

    logic [ADDR_W-1:0]  l1_addr, l2_addr, small_pa, large_pa;
    logic               in_l1;
    logic               up_w, up_u, lo_w, lo_u;
    logic               p_fault;
    logic [ECODE_W-1:0] p_ecode;

    ptw_addr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W)
    ) u_addr (
        .root       (q.root),
        .lin        (q.lin),
        .tbl_entry  (q.e1),
        .leaf_entry (mem_rsp_data),
        .l1_addr    (l1_addr),
        .l2_addr    (l2_addr),
        .small_pa   (small_pa),
        .large_pa   (large_pa)
    );

    // In the first level the lower-level rights are neutral
    always_comb begin
        in_l1 = (q.state == ST_L1_WAIT);
        up_w  = in_l1 ? mem_rsp_data[FLAG_WRITE] : q.e1[FLAG_WRITE];
        up_u  = in_l1 ? mem_rsp_data[FLAG_USER]  : q.e1[FLAG_USER];
        lo_w  = in_l1 ? 1'b1 : mem_rsp_data[FLAG_WRITE];
        lo_u  = in_l1 ? 1'b1 : mem_rsp_data[FLAG_USER];
    end

    ptw_perm u_perm (
        .present (mem_rsp_data[FLAG_PRESENT]),
        .up_w    (up_w),
        .up_u    (up_u),
        .lo_w    (lo_w),
        .lo_u    (lo_u),
        .acc_w   (q.wr),
        .acc_u   (q.usr),
        .fault   (p_fault),
        .ecode   (p_ecode)
    );

    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.lin   = req_lin;
                    d.wr    = req_write;
                    d.usr   = req_user;
                    d.root  = cfg_root;
                    d.lp    = cfg_lp_en;
                    d.fault = 1'b0;
                    d.ecode = '0;
                    if (!cfg_pg_en) begin
                        d.paddr = req_lin;
                        d.state = ST_DONE;
                    end else begin
                        d.state = ST_L1_REQ;
                    end
                end
            end
            ST_L1_REQ: begin
                if (mem_req_ready) d.state = ST_L1_WAIT;
            end
            ST_L1_WAIT: begin
                if (mem_rsp_valid) begin
                    if (!mem_rsp_data[FLAG_PRESENT] ||
                        (q.lp && mem_rsp_data[FLAG_LARGE])) begin
                        d.fault = p_fault;
                        d.ecode = p_ecode;
                        d.paddr = p_fault ? '0 : large_pa;
                        d.state = ST_DONE;
                    end else begin
                        d.e1    = mem_rsp_data;
                        d.state = ST_L2_REQ;
                    end
                end
            end
            ST_L2_REQ: begin
                if (mem_req_ready) d.state = ST_L2_WAIT;
            end
            ST_L2_WAIT: begin
                if (mem_rsp_valid) begin
                    d.fault = p_fault;
                    d.ecode = p_ecode;
                    d.paddr = p_fault ? '0 : small_pa;
                    d.state = ST_DONE;
                end
            end
            ST_DONE: d.state = ST_IDLE;
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        req_ready     = (q.state == ST_IDLE);
        mem_req_valid = (q.state == ST_L1_REQ) || (q.state == ST_L2_REQ);
        mem_req_addr  = (q.state == ST_L2_REQ) ? l2_addr : l1_addr;
        rsp_valid     = (q.state == ST_DONE);
        rsp_fault     = q.fault;
        rsp_paddr     = q.paddr;
        rsp_ecode     = q.ecode;
    end

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_lin,
    input logic        cfg_pg_en,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic [2:0]  rsp_ecode
);

    a_r1_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_pg_en) |=>
            (rsp_valid && !rsp_fault && rsp_paddr == $past(req_lin)));

    a_r1_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cfg_pg_en) |=> !mem_req_valid);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r11_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, mem_req_valid, rsp_valid}));

    a_r10_idle_after: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    a_r9_ok_code: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_ecode == 3'b000));

endmodule

bind ptw_top ptw_checker u_ptw_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_lin       (req_lin),
    .cfg_pg_en     (cfg_pg_en),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_ecode     (rsp_ecode)
);

// File: tb/test_ptw_top.sv
`timescale 1ns/1ps
module test_ptw_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_lin = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic [31:0] cfg_root = '0;
    logic        cfg_pg_en = 1'b0;
    logic        cfg_lp_en = 1'b0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_paddr;
    logic [2:0]  rsp_ecode;

    always #2 clk = ~clk;

    ptw_top i_ptw_top (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
        .req_write(req_write), .req_user(req_user),
        .cfg_root(cfg_root), .cfg_pg_en(cfg_pg_en), .cfg_lp_en(cfg_lp_en),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .rsp_ecode(rsp_ecode)
    );

    typedef struct {
        logic [31:0] pa;
        logic        f;
        logic [2:0]  ec;
        string       tag;
    } exp_t;

    int          n_checks = 0;
    int          n_errors = 0;
    int          done_cnt = 0;
    bit          finished = 0;
    logic [31:0] pmem [logic [31:0]];
    exp_t        rq[$];
    logic [31:0] aq[$];
    string       atq[$];

    function automatic logic [31:0] mrd(logic [31:0] a);
        return pmem.exists(a) ? pmem[a] : 32'h0;
    endfunction

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    // Behavioural reference: pushes expected reads and result
    task automatic model(string tag, logic [31:0] lin, logic w, logic u);
        exp_t e;
        logic [31:0] a1, a2, e1, e2;
        e.tag = tag;
        e.f = 1'b0;
        e.ec = 3'b000;
        if (!cfg_pg_en) begin
            e.pa = lin;
        end else begin
            a1 = (cfg_root & 32'hFFFF_F000) | ((lin >> 22) << 2);
            aq.push_back(a1); atq.push_back({tag, "/R2"});
            e1 = mrd(a1);
            if (!e1[0]) begin
                e.f = 1'b1; e.ec = {u, w, 1'b0}; e.pa = 0;
            end else if (cfg_lp_en && e1[7]) begin
                if ((w && !e1[1]) || (u && !e1[2])) begin
                    e.f = 1'b1; e.ec = {u, w, 1'b1}; e.pa = 0;
                end else begin
                    e.pa = (e1 & 32'hFFC0_0000) | (lin & 32'h003F_FFFF);
                end
            end else begin
                a2 = (e1 & 32'hFFFF_F000) | (((lin >> 12) & 32'h3FF) << 2);
                aq.push_back(a2); atq.push_back({tag, "/R3"});
                e2 = mrd(a2);
                if (!e2[0]) begin
                    e.f = 1'b1; e.ec = {u, w, 1'b0}; e.pa = 0;
                end else if ((w && !(e1[1] && e2[1])) || (u && !(e1[2] && e2[2]))) begin
                    e.f = 1'b1; e.ec = {u, w, 1'b1}; e.pa = 0;
                end else begin
                    e.pa = (e2 & 32'hFFFF_F000) | (lin & 32'hFFF);
                end
            end
        end
        rq.push_back(e);
    endtask

    task automatic issue(string tag, logic [31:0] lin, logic w, logic u);
        int target;
        target = done_cnt + 1;
        while (!req_ready) @(negedge clk);
        model(tag, lin, w, u);
        req_valid = 1'b1; req_lin = lin; req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt != target) @(negedge clk);
        check({tag, "/reads"}, aq.size(), 0);
    endtask

    // Memory responder and per-clock comparison
    initial begin
        int  cyc = 0;
        bit  pend = 0;
        int  dly = 0;
        bit  idle_chk = 0;
        logic [31:0] pdata = '0;
        exp_t e;
        forever begin
            @(negedge clk);
            cyc++;
            if (rst_n) begin
                if (idle_chk) begin
                    check("R10 idle after response", req_ready, 1);
                    idle_chk = 0;
                end
                if (rsp_valid) begin
                    if (rq.size() == 0) begin
                        check("R10 unexpected response", 1, 0);
                    end else begin
                        e = rq.pop_front();
                        check({e.tag, " paddr"}, rsp_paddr, e.pa);
                        check({e.tag, " fault"}, rsp_fault, e.f);
                        check({e.tag, " ecode R9"}, rsp_ecode, e.ec);
                    end
                    done_cnt++;
                    idle_chk = 1;
                end
                if (mem_rsp_valid) mem_rsp_valid = 1'b0;
                if (pend) begin
                    if (dly == 0) begin
                        mem_rsp_valid = 1'b1; mem_rsp_data = pdata; pend = 0;
                    end else dly--;
                end
                mem_req_ready = (cyc % 3) != 1;
                if (mem_req_valid && mem_req_ready) begin
                    if (aq.size() == 0) begin
                        check("R11 unexpected read", mem_req_addr, 32'hFFFF_FFFF);
                    end else begin
                        check(atq.pop_front(), mem_req_addr, aq.pop_front());
                    end
                    pend = 1; dly = cyc % 2; pdata = mrd(mem_req_addr);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        pmem[32'h0001_0004] = 32'h0002_0007;
        pmem[32'h0002_0004] = 32'h0005_5007;
        pmem[32'h0002_0008] = 32'h0006_6005;
        pmem[32'h0001_0008] = 32'h0300_0087;
        pmem[32'h0001_000C] = 32'h0003_0003;
        pmem[32'h0003_0000] = 32'h0007_7007;
        pmem[32'h0001_0010] = 32'h0500_0085;
        pmem[32'h0001_0FFC] = 32'h0004_0007;
        pmem[32'h0004_0FFC] = 32'hABCD_E007;
        pmem[32'h0009_0004] = 32'h0008_0007;
        pmem[32'h0008_0004] = 32'h0001_2007;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 reset ready", req_ready, 1);
        check("R11 reset no read", mem_req_valid, 0);
        check("R10 reset no response", rsp_valid, 0);

        cfg_pg_en = 1'b0;
        issue("R1 passthrough", 32'hDEAD_BEEF, 1'b1, 1'b1);
        cfg_pg_en = 1'b1; cfg_lp_en = 1'b1; cfg_root = 32'h0001_0ABC;
        issue("R4 small read", 32'h0040_1234, 1'b0, 1'b1);
        issue("R4 small write", 32'h0040_1FFF, 1'b1, 1'b0);
        issue("R8 read-only write", 32'h0040_2010, 1'b1, 1'b1);
        issue("R8 read-only read", 32'h0040_2010, 1'b0, 1'b1);
        issue("R7 second level absent", 32'h0040_3000, 1'b1, 1'b0);
        issue("R7 first level absent", 32'h0140_0000, 1'b0, 1'b1);
        issue("R5 large page", 32'h0089_ABCD, 1'b1, 1'b1);
        issue("R8 large read-only write", 32'h0100_0004, 1'b1, 1'b0);
        issue("R5 large read-only read", 32'h0100_0004, 1'b0, 1'b1);
        issue("R8 supervisor entry user", 32'h00C0_0123, 1'b0, 1'b1);
        issue("R8 supervisor entry kernel", 32'h00C0_0123, 1'b1, 1'b0);
        issue("R3 top index", 32'hFFFF_FFFF, 1'b0, 1'b0);
        cfg_lp_en = 1'b0;
        issue("R6 size flag ignored", 32'h0089_ABCD, 1'b0, 1'b0);
        cfg_lp_en = 1'b1; cfg_root = 32'h0009_0000;
        issue("R2 other root", 32'h0040_1234, 1'b0, 1'b0);
        cfg_pg_en = 1'b0;
        issue("R1 passthrough zero", 32'h0000_0000, 1'b0, 1'b0);

        repeat (3) @(negedge clk);
        report();
    end

endmodule